// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers sixteen level-sensitive request lines from peripherals on a local bus and merges them into a single interrupt request for the processor. Each line passes through a two-stage synchronizer into a status bit that follows the line's level. An enable mask selects which status bits take part. The combined request is high whenever any enabled status bit is set.

A small 16-bit register port serves software. One location returns a code for the most urgent enabled request. The lowest line number wins, and the code is the line number plus one, shifted up by two bits. A code of zero therefore means that nothing is pending. A second location holds the enable mask, which software can read and write. Only the low twelve address bits are decoded. Writes to any location other than the mask are dropped, and reads from unknown locations return zero.

Top module: `lbus_irq_ctrl`

## Requirements
- R1: Each of the 16 request lines drives its own status bit through two flops. A level change on a line that is sampled at rising edge k shows in the status, and so on `irq_o`, after rising edge k+1. The status bit clears again once the line is low.
- R2: `irq_o` is high exactly when the bitwise AND of status and mask is non-zero. A mask write changes `irq_o` at the same edge that loads the mask.
- R3: A read at offset 0x000 returns (i+1)<<2, where i is the lowest-numbered bit set in status AND mask. Line 0 gives 0x0004 and line 15 gives 0x0040. The read returns 0x0000 when no enabled line is pending.
- R4: Read data is registered. `bus_rdata_o` takes the addressed value at the rising edge where `bus_rd_i` is high, and it holds that value while `bus_rd_i` is low. A read from any offset other than 0x000 or 0x002 returns 0x0000.
- R5: Offset 0x002 is the enable mask, read and written as a whole 16-bit word. Bit n enables line n.
- R6: Only the address modulo 0x1000 (bits 11:0) is decoded. Address bits above bit 11 do not affect which register is selected.
- R7: A write to any offset other than 0x002 leaves the mask and `irq_o` unchanged.
- R8: While reset is asserted, the mask is 0x0010, the status is all zero, `irq_o` is low and `bus_rdata_o` is zero.
- R9: A pending line whose mask bit is clear neither raises `irq_o` nor appears in the code read at 0x000. A higher-numbered enabled line is reported in its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| irq_line_i | input | 16 | Level-sensitive request lines, one per peripheral |
| bus_addr_i | input | 16 | Register byte address; bits 11:0 decoded |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong status or synchronizer bit shows at `irq_o` two edges after the line moves. It also shows in the source code, which reads the wrong line number or zero on the next read. A corrupted mask shows at once on `irq_o` and in the first read-back of offset 0x002. A decode fault that lets a stray write reach the mask is caught by reading the mask back right after the write. An encoder that picks the wrong line is exposed by patterns with several pending lines, and by lines at both ends of the range.

// File: rtl/lbirq_pkg.sv
package lbirq_pkg;
  localparam int unsigned DEC_W = 12;
  localparam logic [DEC_W-1:0] OFS_CODE = 12'h000;
  localparam logic [DEC_W-1:0] OFS_MASK = 12'h002;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CODE = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/lbirq_sync.sv
module lbirq_sync #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] level_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q;
    logic s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= line_i[g];
        s2_q <= s1_q;
      end
    end
    assign level_o[g] = s2_q;
  end

  // cycles since reset, for the latency check only
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                warm_q <= 2'd0;
    else if (warm_q != 2'd2)   warm_q <= warm_q + 2'd1;
  end

  // R1: status equals the line level two edges earlier
  a_r1_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (level_o == $past(line_i, 2)));

endmodule

// File: rtl/lbirq_prio.sv
module lbirq_prio #(
  parameter int unsigned N     = 16,
  parameter int unsigned VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pend_i,
  output logic [VEC_W-1:0] code_o
);
  localparam int unsigned IDX_W = $clog2(N);

  // lowest index wins: scan downward so the last hit is the lowest line
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) code_o = VEC_W'((i + 1) << 2);
    end
  end

  logic [VEC_W-3:0] code_num;
  logic [IDX_W-1:0] hit_idx;
  logic [N-1:0]     below_mask;
  assign code_num   = code_o[VEC_W-1:2];
  assign hit_idx    = IDX_W'(code_num - (VEC_W-2)'(1));
  assign below_mask = (N'(1) << hit_idx) - N'(1);

  // R3: zero code exactly when nothing enabled is pending
  a_r3_zero_iff_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == '0) == (pend_i == '0));
  // R3: reported line is pending
  a_r3_hit_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != '0) |-> pend_i[hit_idx]);
  // R3: no lower-numbered line is pending
  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != '0) |-> ((pend_i & below_mask) == '0));

endmodule

// File: rtl/lbirq_regs.sv
module lbirq_regs
  import lbirq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned N        = 16,
  parameter logic [N-1:0] RST_MASK = N'(16'h0010)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] code_i,
  output logic [N-1:0]      mask_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] KEEP = ADDR_W'((1 << DEC_W) - 1);

  logic [ADDR_W-1:0] off_c;
  reg_sel_e          sel_c;
  logic [N-1:0]      mask_q, mask_d;
  logic              mask_en;
  logic [DATA_W-1:0] rdata_q, rdata_d, rsel_c;

  assign off_c = addr_i & KEEP;

  always_comb begin
    if (off_c == ADDR_W'(OFS_CODE))      sel_c = SEL_CODE;
    else if (off_c == ADDR_W'(OFS_MASK)) sel_c = SEL_MASK;
    else                                 sel_c = SEL_NONE;
  end

  // next state
  always_comb begin
    mask_en = wr_i && (sel_c == SEL_MASK);
    mask_d  = mask_q;
    if (mask_en) mask_d = wdata_i[N-1:0];
    case (sel_c)
      SEL_CODE: rsel_c = code_i;
      SEL_MASK: rsel_c = DATA_W'(mask_q);
      default:  rsel_c = '0;
    endcase
    rdata_d = rd_i ? rsel_c : rdata_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= RST_MASK;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_d;
      rdata_q <= rdata_d;
    end
  end

  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;

  // R5: a mask write loads the whole word
  a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ((addr_i & KEEP) == ADDR_W'(OFS_MASK))) |=> (mask_o == $past(wdata_i[N-1:0])));
  // R7: other writes leave the mask alone
  a_r7_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && ((addr_i & KEEP) == ADDR_W'(OFS_MASK))) |=> $stable(mask_o));
  // R4: read data holds between reads
  a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/lbus_irq_ctrl.sv
module lbus_irq_ctrl
  import lbirq_pkg::*;
#(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter logic [N_SRC-1:0] RST_MASK = N_SRC'(16'h0010)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_line_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] KEEP = ADDR_W'((1 << DEC_W) - 1);

  logic [N_SRC-1:0]  status;
  logic [N_SRC-1:0]  mask;
  logic [N_SRC-1:0]  pend;
  logic [DATA_W-1:0] code;

  lbirq_sync #(.N(N_SRC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (irq_line_i),
    .level_o (status)
  );

  assign pend  = status & mask;
  assign irq_o = |pend;

  lbirq_prio #(.N(N_SRC), .VEC_W(DATA_W)) u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend),
    .code_o (code)
  );

  lbirq_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .N        (N_SRC),
    .RST_MASK (RST_MASK)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (bus_addr_i),
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .wdata_i (bus_wdata_i),
    .code_i  (code),
    .mask_o  (mask),
    .rdata_o (bus_rdata_o)
  );

  // R2/R3: a code read is non-zero exactly when the request was raised
  a_r2_code_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && ((bus_addr_i & KEEP) == ADDR_W'(OFS_CODE)))
      |=> ((bus_rdata_o != '0) == $past(irq_o)));

endmodule

// File: tb/sim_lbus_irq_ctrl.sv
module sim_lbus_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [15:0] lines = '0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] m_lines = '0;
  logic [15:0] m_mask = 16'h0010;

  always #4 clk = ~clk;

  lbus_irq_ctrl u0 (
    .clk (clk), .rst_n (rst_n), .irq_line_i (lines),
    .bus_addr_i (addr), .bus_wr_i (wr), .bus_rd_i (rd),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata), .irq_o (irq)
  );

  function automatic logic [15:0] ref_code(logic [15:0] l, logic [15:0] m);
    logic [15:0] p = l & m;
    for (int i = 0; i < 16; i++) if (p[i]) return 16'((i + 1) << 2);
    return 16'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic set_lines(logic [15:0] v, bit chk_lat);
    logic old_irq = |(m_lines & m_mask);
    @(negedge clk); lines = v;
    @(negedge clk);
    if (chk_lat) chk("R1 latency", irq, old_irq);
    m_lines = v;
    @(negedge clk);
  endtask

  task automatic check_state(string req);
    logic [15:0] d;
    chk({req, " irq"}, irq, |(m_lines & m_mask));
    bus_read(16'h0000, d);
    chk({req, " code"}, d, ref_code(m_lines, m_mask));
  endtask

  task automatic t_reset();
    logic [15:0] d;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 irq in reset", irq, 0);
    chk("R8 rdata in reset", rdata, 0);
    rst_n = 1'b1;
    bus_read(16'h0002, d);
    chk("R8 mask reset", d, 16'h0010);
    bus_read(16'h0000, d);
    chk("R8 code reset", d, 16'h0000);
  endtask

  task automatic t_single_lines();
    bus_write(16'h0002, 16'hFFFF); m_mask = 16'hFFFF;
    for (int i = 0; i < 16; i++) begin
      set_lines(16'(1 << i), 1'b1);
      check_state("R3 single");
      set_lines(16'h0, 1'b1);
      check_state("R1 release");
    end
  endtask

  task automatic t_priority();
    logic [15:0] pats [5] = '{16'hF0F0, 16'h8000, 16'h8001, 16'h0006, 16'hFFFF};
    for (int k = 0; k < 5; k++) begin
      set_lines(pats[k], 1'b0);
      check_state("R3 priority");
    end
  endtask

  task automatic t_masking();
    set_lines(16'h00FF, 1'b0);
    bus_write(16'h0002, 16'h00F0); m_mask = 16'h00F0;
    chk("R2 mask write edge", irq, 1);
    check_state("R9 partial mask");
    bus_write(16'h0002, 16'hFF00); m_mask = 16'hFF00;
    chk("R2 mask off same edge", irq, 0);
    check_state("R9 all masked");
    set_lines(16'h0101, 1'b0);
    check_state("R9 higher line wins");
    set_lines(16'h0000, 1'b0);
  endtask

  task automatic t_mask_rw();
    logic [15:0] d;
    bus_write(16'h0002, 16'hA5C3); m_mask = 16'hA5C3;
    bus_read(16'h0002, d);
    chk("R5 mask readback", d, 16'hA5C3);
  endtask

  task automatic t_alias();
    logic [15:0] d;
    bus_write(16'h3002, 16'h1234); m_mask = 16'h1234;
    bus_read(16'h5002, d);
    chk("R6 alias mask", d, 16'h1234);
    set_lines(16'h0030, 1'b0);
    bus_read(16'hF000, d);
    chk("R6 alias code", d, ref_code(m_lines, m_mask));
  endtask

  task automatic t_ignored();
    logic [15:0] d;
    bus_write(16'h0000, 16'hFFFF);
    bus_write(16'h0004, 16'hFFFF);
    bus_write(16'h0003, 16'hFFFF);
    bus_write(16'h0FFE, 16'h0000);
    bus_read(16'h0002, d);
    chk("R7 mask kept", d, m_mask);
    chk("R7 irq kept", irq, |(m_lines & m_mask));
  endtask

  task automatic t_unknown();
    logic [15:0] d;
    bus_read(16'h0004, d); chk("R4 unknown 0x004", d, 0);
    bus_read(16'h0001, d); chk("R4 unknown 0x001", d, 0);
    bus_read(16'h0100, d); chk("R4 unknown 0x100", d, 0);
    bus_read(16'h0002, d);
    set_lines(16'h0000, 1'b0);
    repeat (4) @(negedge clk);
    chk("R4 rdata held", rdata, m_mask);
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single_lines();
    t_priority();
    t_masking();
    t_mask_rw();
    t_alias();
    t_ignored();
    t_unknown();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule